// File: doc/BRIEF.md
# Fly-by DMA Peripheral Bus Bridge

This block sits between a slave port of the system bus and a simple peripheral bus. It handles two kinds of traffic. The first is ordinary register access, where the peripheral is picked by decoding the address. The second is fly-by DMA, where the DMA controller owns the system bus and data moves directly between memory and a DMA-capable peripheral. The bridge takes no part in that data path.

During a DMA cycle, the DMA controller raises a DMA-active flag and supplies a 2-bit channel number. The bridge then asserts that channel's dedicated DMA select in place of any address-decoded select, and forces the peripheral address to zero because it carries no meaning. It also drives the peripheral write line with the opposite sense of the system-bus write. A system-bus write means memory is the destination, so the peripheral is being read. Everything else about the transfer comes from the system-bus signals the bridge monitors.

Every accepted transfer takes two clocks: a setup cycle, then a strobe cycle. In the strobe cycle the peripheral strobe qualifies the data and the bridge reports completion to the system bus.

Top module: `flyby_bridge`

## Requirements
- R1: After reset, and whenever no transfer is in progress, every normal select, every DMA select, `perStrobe`, `busDone`, `perWrite` and `perAddr` are low.
- R2: A transfer is accepted only when the bridge is idle and `busTrans` is 2'b10 or 2'b11. The codes 2'b00 (idle) and 2'b01 (busy) start nothing.
- R3: In a normal access, `perSel[k]` is high, with k equal to bits [15:12] of the captured address, for the two cycles after acceptance. During those cycles `perAddr` equals the captured address and `perWrite` equals the captured `busWrite`.
- R4: In a DMA access (`dmaActive` high at acceptance), `perDmaSel[c]` is high for the two cycles after acceptance, where c is the captured `dmaChan`. All normal selects stay low.
- R5: In a DMA access, `perWrite` is the inverse of the captured `busWrite`.
- R6: In a DMA access, `perAddr` is driven to zero whatever the system-bus address is.
- R7: `perStrobe` is high for exactly one clock, the second cycle after acceptance. `busDone` is high in that same cycle and in no other.
- R8: If `dmaActive` is high while a valid transfer type is presented, the transfer is handled as DMA and no normal select is asserted.
- R9: Transfer requests presented during the setup or strobe cycle are ignored. They change no output.
- R10: `perWdata` follows `busWdata` and `busRdata` follows `perRdata` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 32 | System-bus address |
| busWrite | input | 1 | System-bus write direction |
| busTrans | input | 2 | System-bus transfer type |
| busWdata | input | 32 | System-bus write data |
| busRdata | output | 32 | Read data returned to the system bus |
| busDone | output | 1 | Transfer complete |
| dmaActive | input | 1 | Current transfer is a fly-by DMA cycle |
| dmaChan | input | 2 | DMA channel number |
| perAddr | output | 32 | Peripheral address |
| perWrite | output | 1 | Peripheral write |
| perStrobe | output | 1 | Peripheral data strobe |
| perWdata | output | 32 | Peripheral write data |
| perRdata | input | 32 | Peripheral read data |
| perSel | output | 16 | Address-decoded peripheral selects |
| perDmaSel | output | 4 | Per-channel DMA selects |

## Verification
The hardest situation to reach is a fresh, valid request, possibly with `dmaActive` and a different channel, arriving while a transfer is already in its setup or strobe cycle. A request presented in the idle state would simply be accepted. To reach the busy case, the stimulus drives a conflicting request on the clock after acceptance and holds it through the strobe cycle. The expected outputs keep the first transfer's selects, write sense and address. A DMA cycle with a non-zero bus address, and a DMA request that carries a normal-looking address, cover the priority and address-masking corners.

// File: rtl/flyby_pkg.sv
package flyby_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2
  } phase_t;

  typedef struct packed {
    logic load;    // capture request fields this cycle
    logic hold;    // a transfer occupies the peripheral bus
    logic strobe;  // data phase of the transfer
  } ctrlStrobes_t;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_BUSY   = 2'b01;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;

endpackage

// File: rtl/flyby_ctrl.sv
module flyby_ctrl
  import flyby_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   busTrans,
  output ctrlStrobes_t ctrl,
  output logic         busDone
);

  phase_t phase, phaseNext;
  logic   start;

  assign start = (phase == PH_IDLE) &&
                 ((busTrans == TRANS_NONSEQ) || (busTrans == TRANS_SEQ));

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE:   if (start) phaseNext = PH_SETUP;
      PH_SETUP:  phaseNext = PH_STROBE;
      PH_STROBE: phaseNext = PH_IDLE;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    ctrl.load   = start;
    ctrl.hold   = (phase == PH_SETUP) || (phase == PH_STROBE);
    ctrl.strobe = (phase == PH_STROBE);
  end

  assign busDone = (phase == PH_STROBE);

  // R7: data phase is always preceded by a setup phase
  assert_strobe_after_setup_R7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STROBE) |-> ($past(phase) == PH_SETUP));

  // R9: a request during a busy phase never starts a new setup
  assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> (phase != PH_SETUP));

endmodule

// File: rtl/flyby_dp.sv
module flyby_dp
  import flyby_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int SLOT_BITS = 4,
  parameter int SLOT_LSB  = 12,
  parameter int CHAN_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         ctrl,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWrite,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic                 dmaActive,
  input  logic [CHAN_W-1:0]    dmaChan,
  output logic [ADDR_W-1:0]    perAddr,
  output logic                 perWrite,
  output logic                 perStrobe,
  output logic [DATA_W-1:0]    perWdata,
  input  logic [DATA_W-1:0]    perRdata,
  output logic [(1<<SLOT_BITS)-1:0] perSel,
  output logic [(1<<CHAN_W)-1:0]    perDmaSel
);

  localparam int NUM_SLOTS = 1 << SLOT_BITS;
  localparam int NUM_CHAN  = 1 << CHAN_W;

  logic [ADDR_W-1:0]    addrQ;
  logic                 writeQ;
  logic                 dmaQ;
  logic [CHAN_W-1:0]    chanQ;
  logic [SLOT_BITS-1:0] slotQ;
  logic                 normalOn;
  logic                 dmaOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      writeQ <= 1'b0;
      dmaQ   <= 1'b0;
      chanQ  <= '0;
    end else if (ctrl.load) begin
      addrQ  <= busAddr;
      writeQ <= busWrite;
      dmaQ   <= dmaActive;
      chanQ  <= dmaChan;
    end
  end

  assign slotQ    = addrQ[SLOT_LSB +: SLOT_BITS];
  assign normalOn = ctrl.hold && !dmaQ;
  assign dmaOn    = ctrl.hold && dmaQ;

  assign perAddr   = normalOn ? addrQ : '0;
  assign perWrite  = ctrl.hold && (dmaQ ? ~writeQ : writeQ);
  assign perStrobe = ctrl.strobe;
  assign perWdata  = busWdata;
  assign busRdata  = perRdata;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
    assign perSel[s] = normalOn && (slotQ == SLOT_BITS'(s));
  end

  for (genvar c = 0; c < NUM_CHAN; c++) begin : gChan
    assign perDmaSel[c] = dmaOn && (chanQ == CHAN_W'(c));
  end

  // R8: normal and DMA selects never overlap
  assert_sel_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !((|perSel) && (|perDmaSel)));

  // R3: at most one address-decoded select
  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(perSel));

  // R4: at most one DMA select
  assert_dmasel_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(perDmaSel));

  // R3: address and direction held from setup into the strobe cycle
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    perStrobe |-> ($stable(perAddr) && $stable(perWrite)));

  // R7: the strobe never lasts two clocks
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    perStrobe |=> !perStrobe);

  // R7: strobe only while some peripheral is selected
  assert_strobe_selected_R7: assert property (@(posedge clk) disable iff (!rstN)
    perStrobe |-> ((|perSel) || (|perDmaSel)));

endmodule

// File: rtl/flyby_bridge.sv
module flyby_bridge
  import flyby_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] busAddr,
  input  logic        busWrite,
  input  logic [1:0]  busTrans,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        busDone,
  input  logic        dmaActive,
  input  logic [1:0]  dmaChan,
  output logic [31:0] perAddr,
  output logic        perWrite,
  output logic        perStrobe,
  output logic [31:0] perWdata,
  input  logic [31:0] perRdata,
  output logic [15:0] perSel,
  output logic [3:0]  perDmaSel
);

  ctrlStrobes_t ctrl;

  flyby_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busTrans (busTrans),
    .ctrl     (ctrl),
    .busDone  (busDone)
  );

  flyby_dp #(
    .ADDR_W    (32),
    .DATA_W    (32),
    .SLOT_BITS (4),
    .SLOT_LSB  (12),
    .CHAN_W    (2)
  ) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .busAddr   (busAddr),
    .busWrite  (busWrite),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .dmaActive (dmaActive),
    .dmaChan   (dmaChan),
    .perAddr   (perAddr),
    .perWrite  (perWrite),
    .perStrobe (perStrobe),
    .perWdata  (perWdata),
    .perRdata  (perRdata),
    .perSel    (perSel),
    .perDmaSel (perDmaSel)
  );

  // R7: completion to the system bus coincides with the peripheral strobe
  assert_done_with_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    busDone == perStrobe);

endmodule

// File: tb/test_flyby_bridge.sv
module test_flyby_bridge;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busWrite = 1'b0;
  logic [1:0]  busTrans = 2'b00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busDone;
  logic        dmaActive = 1'b0;
  logic [1:0]  dmaChan = '0;
  logic [31:0] perAddr;
  logic        perWrite;
  logic        perStrobe;
  logic [31:0] perWdata;
  logic [31:0] perRdata = '0;
  logic [15:0] perSel;
  logic [3:0]  perDmaSel;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [15:0] sel;
    logic [3:0]  dsel;
    logic        strobe;
    logic        done;
    logic        wr;
    logic [31:0] addr;
    string       tag;
  } expect_t;

  expect_t q[$];

  always #2 clk = ~clk;

  flyby_bridge i_flyby_bridge (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrite(busWrite),
    .busTrans(busTrans), .busWdata(busWdata), .busRdata(busRdata),
    .busDone(busDone), .dmaActive(dmaActive), .dmaChan(dmaChan),
    .perAddr(perAddr), .perWrite(perWrite), .perStrobe(perStrobe),
    .perWdata(perWdata), .perRdata(perRdata), .perSel(perSel),
    .perDmaSel(perDmaSel)
  );

  function automatic expect_t idleExp(string tag);
    expect_t e;
    e.sel = '0; e.dsel = '0; e.strobe = 1'b0; e.done = 1'b0;
    e.wr = 1'b0; e.addr = '0; e.tag = tag;
    return e;
  endfunction

  // Monitor: compares one expected record per clock, just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        expect_t e;
        e = q.pop_front();
        checks++;
        if (perSel !== e.sel || perDmaSel !== e.dsel || perStrobe !== e.strobe ||
            busDone !== e.done || perWrite !== e.wr || perAddr !== e.addr) begin
          errors++;
          $display("FAIL %s: got sel=%h dsel=%h stb=%b done=%b wr=%b addr=%h exp sel=%h dsel=%h stb=%b done=%b wr=%b addr=%h",
                   e.tag, perSel, perDmaSel, perStrobe, busDone, perWrite, perAddr,
                   e.sel, e.dsel, e.strobe, e.done, e.wr, e.addr);
        end
      end
    end
  end

  // Driver: one two-cycle transfer, optionally poking a rival request while busy
  task automatic doXfer(input logic [31:0] a, input logic w, input logic [1:0] t,
                        input logic d, input logic [1:0] ch, input logic poke,
                        input string tag);
    expect_t e;
    busAddr = a; busWrite = w; busTrans = t; dmaActive = d; dmaChan = ch;
    e.sel    = d ? 16'h0 : (16'h1 << a[15:12]);
    e.dsel   = d ? (4'h1 << ch) : 4'h0;
    e.wr     = d ? ~w : w;
    e.addr   = d ? 32'h0 : a;
    e.strobe = 1'b0; e.done = 1'b0; e.tag = {tag, " setup"};
    q.push_back(e);
    e.strobe = 1'b1; e.done = 1'b1; e.tag = {tag, " strobe"};
    q.push_back(e);
    q.push_back(idleExp({tag, " after"}));
    @(negedge clk);
    if (poke) begin
      // R9: rival request with opposite kind, channel and direction
      busAddr = 32'h0000_9000; busWrite = ~w; busTrans = 2'b10;
      dmaActive = ~d; dmaChan = ch + 2'd1;
    end else begin
      busTrans = 2'b00; dmaActive = 1'b0;
    end
    @(negedge clk);
    @(negedge clk);
    busTrans = 2'b00; dmaActive = 1'b0;
  endtask

  task automatic doIgnored(input logic [1:0] t, input string tag);
    busAddr = 32'h0000_5000; busWrite = 1'b1; busTrans = t; dmaActive = 1'b0;
    q.push_back(idleExp(tag));
    @(negedge clk);
    busTrans = 2'b00;
    q.push_back(idleExp(tag));
    @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got hung run exp completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (perSel !== '0 || perDmaSel !== '0 || perStrobe !== 1'b0 || busDone !== 1'b0 ||
        perWrite !== 1'b0 || perAddr !== '0) begin
      errors++;
      $display("FAIL R1 reset: got sel=%h dsel=%h stb=%b done=%b exp all zero",
               perSel, perDmaSel, perStrobe, busDone);
    end
    rstN = 1'b1;
    @(negedge clk);

    doIgnored(2'b00, "R2 idle code");
    doIgnored(2'b01, "R2 busy code");
    doXfer(32'h0000_3ABC, 1'b1, 2'b10, 1'b0, 2'd0, 1'b0, "R3 R7 normal write slot3");
    doXfer(32'hF000_F004, 1'b0, 2'b11, 1'b0, 2'd0, 1'b0, "R2 R3 normal read slot15");
    doXfer(32'h0000_0010, 1'b1, 2'b10, 1'b0, 2'd0, 1'b0, "R3 slot0");
    doXfer(32'h0000_0000, 1'b1, 2'b10, 1'b1, 2'd0, 1'b0, "R4 R5 dma ch0 buswrite");
    doXfer(32'h1234_5678, 1'b0, 2'b10, 1'b1, 2'd3, 1'b0, "R5 R6 dma ch3 busread");
    doXfer(32'h0000_7000, 1'b1, 2'b11, 1'b1, 2'd2, 1'b0, "R8 dma wins ch2");
    doXfer(32'h0000_4000, 1'b0, 2'b10, 1'b0, 2'd1, 1'b1, "R9 normal busy poke");
    doXfer(32'h0000_0000, 1'b1, 2'b10, 1'b1, 2'd1, 1'b1, "R9 dma busy poke");

    wait (q.size() == 0);
    @(negedge clk);

    // R10: data passes straight through
    busWdata = 32'hA5C3_1E0F; perRdata = 32'h5A3C_E1F0;
    #1;
    checks++;
    if (perWdata !== 32'hA5C3_1E0F || busRdata !== 32'h5A3C_E1F0) begin
      errors++;
      $display("FAIL R10: got wdata=%h rdata=%h exp wdata=%h rdata=%h",
               perWdata, busRdata, 32'hA5C3_1E0F, 32'h5A3C_E1F0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule